// File: doc/BRIEF.md
# Reclosing Reset Timer Controller

This block is the reset-timing part of a breaker auto-reclosing sequencer. It holds the sequencer in exactly one of three states: Reset (idle and ready), Reclose Cycle (a reclose attempt is in progress) and Lockout (reclosing has given up). External logic decides when a cycle or a lockout begins and when a reset may start. This block measures the reset interval and returns the sequencer to Reset when that interval completes.

A reset request arms a down-counter. The load value depends on the current state: one programmable interval applies when leaving a reclose cycle, and a second applies when leaving lockout. A hold input freezes the timer and keeps it loaded at the full interval. A reset can therefore only complete after an uninterrupted run. A status flag shows when the timer is actually counting. A cycle or lockout request always takes priority and cancels any timing in progress.

Top module: `reclose_reset_timer`

## Requirements
- R1: Exactly one of `st_reset`, `st_cycle` and `st_lockout` is high in every cycle after reset. `st_cycle` is high only in the Reclose Cycle state.
- R2: A `reset_req` sampled in the Reclose Cycle state, with the timer idle and no other request, arms the timer with `cyc_time`. The state becomes Reset at the clock edge `cyc_time`+1 edges after the arming edge, provided `hold_rst` stays low.
- R3: A `reset_req` sampled in the Lockout state arms the timer with `lko_time`. The state moves from Lockout to Reset at the edge `lko_time`+1 edges after the arming edge, with no further delay.
- R4: While `hold_rst` is high, an armed timer does not advance, the state does not change to Reset, and the timer stays armed.
- R5: After `hold_rst` falls, timing restarts from the full interval. Reset is reached at the edge interval+1 edges after the last edge at which `hold_rst` was sampled high.
- R6: `timing_active` is high exactly when the timer is armed and `hold_rst` is low.
- R7: An interval of zero completes at the first edge after arming.
- R8: A sampled `lockout_req` moves the state to Lockout at the next edge. A sampled `cycle_req` without `lockout_req` moves it to Reclose Cycle. Either request disarms the timer. `lockout_req` wins over `cycle_req`.
- R9: `reset_req` has no effect in the Reset state, and it has no effect while the timer is already armed (no restart).
- R10: A synchronous `rst` puts the block in the Reset state with the timer disarmed and `timing_active` low.
- R11: A request arriving at the expiry edge wins over the expiry. `hold_rst` high at the edge where the count has reached zero prevents the expiry and reloads the full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reset_req | input | 1 | Start reset timing (strobe or level) |
| cycle_req | input | 1 | Enter Reclose Cycle state |
| lockout_req | input | 1 | Enter Lockout state |
| hold_rst | input | 1 | Registered level that halts reset timing and forces a full reload |
| cyc_time | input | TW | Reset interval in ticks when leaving Reclose Cycle |
| lko_time | input | TW | Reset interval in ticks when leaving Lockout |
| st_reset | output | 1 | Reset state indication |
| st_cycle | output | 1 | Reclose Cycle state indication |
| st_lockout | output | 1 | Lockout state indication |
| timing_active | output | 1 | Reset timer counting |

## Verification
Two pairs of events can land in the same cycle. The first pair is the timer's expiry and a cycle or lockout request. The second pair is the expiry and a rising hold. The bench reaches both by arming a short interval, counting the edges to the zero count, and then asserting the request or the hold exactly at the expiry edge. The request must win and leave the state on the requested value. The hold must block the expiry and cause a full reload, which the bench confirms by counting the edges to Reset after release.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

  typedef enum logic [1:0] {
    ST_RESET   = 2'd0,
    ST_CYCLE   = 2'd1,
    ST_LOCKOUT = 2'd2
  } rrt_state_e;

  // Decode a state into its three indication bits {lockout, cycle, reset}
  function automatic logic [2:0] state_bits(input rrt_state_e s);
    case (s)
      ST_CYCLE:   state_bits = 3'b010;
      ST_LOCKOUT: state_bits = 3'b100;
      default:    state_bits = 3'b001;
    endcase
  endfunction

  // Next state from requests and timer expiry; lockout outranks cycle, both outrank expiry
  function automatic rrt_state_e next_state(input rrt_state_e s, input logic lko,
                                            input logic cyc, input logic expired);
    if (lko)          next_state = ST_LOCKOUT;
    else if (cyc)     next_state = ST_CYCLE;
    else if (expired) next_state = ST_RESET;
    else              next_state = s;
  endfunction

endpackage

// File: rtl/rrt_time_sel.sv
module rrt_time_sel
  import rrt_pkg::*;
#(
  parameter int TW = 16
) (
  input  rrt_state_e    state,
  input  logic [TW-1:0] cyc_time,
  input  logic [TW-1:0] lko_time,
  output logic [TW-1:0] sel_time
);

  function automatic logic [TW-1:0] pick_time(input rrt_state_e s,
                                              input logic [TW-1:0] c,
                                              input logic [TW-1:0] l);
    pick_time = (s == ST_LOCKOUT) ? l : c;
  endfunction

  assign sel_time = pick_time(state, cyc_time, lko_time);

endmodule

// File: rtl/rrt_down_timer.sv
module rrt_down_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic          hold,
  input  logic [TW-1:0] load_val,
  output logic          armed,
  output logic          expire
);

  logic [TW-1:0] cnt_q;

  function automatic logic at_zero(input logic [TW-1:0] c);
    at_zero = (c == '0);
  endfunction

  assign expire = armed && !hold && !abort && at_zero(cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt_q <= '0;
    end else if (abort) begin
      armed <= 1'b0;
    end else if (armed) begin
      if (hold)               cnt_q <= load_val;
      else if (at_zero(cnt_q)) armed <= 1'b0;
      else                     cnt_q <= cnt_q - 1'b1;
    end else if (start) begin
      armed <= 1'b1;
      cnt_q <= load_val;
    end
  end

endmodule

// File: rtl/rrt_state_fsm.sv
module rrt_state_fsm
  import rrt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lko_req,
  input  logic       cyc_req,
  input  logic       expire,
  output rrt_state_e state
);

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RESET;
    else     state <= next_state(state, lko_req, cyc_req, expire);
  end

endmodule

// File: rtl/reclose_reset_timer.sv
module reclose_reset_timer
  import rrt_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reset_req,
  input  logic          cycle_req,
  input  logic          lockout_req,
  input  logic          hold_rst,
  input  logic [TW-1:0] cyc_time,
  input  logic [TW-1:0] lko_time,
  output logic          st_reset,
  output logic          st_cycle,
  output logic          st_lockout,
  output logic          timing_active
);

  rrt_state_e    state;
  logic [TW-1:0] sel_time;
  logic          tmr_armed;
  logic          ev_expire;
  logic          ev_abort;
  logic          ev_start;
  logic [2:0]    st_vec;

  assign ev_abort = lockout_req || cycle_req;
  assign ev_start = reset_req && (state != ST_RESET) && !tmr_armed && !ev_abort;

  rrt_time_sel #(.TW(TW)) u_sel (
    .state    (state),
    .cyc_time (cyc_time),
    .lko_time (lko_time),
    .sel_time (sel_time)
  );

  rrt_down_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .start    (ev_start),
    .abort    (ev_abort),
    .hold     (hold_rst),
    .load_val (sel_time),
    .armed    (tmr_armed),
    .expire   (ev_expire)
  );

  rrt_state_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .lko_req (lockout_req),
    .cyc_req (cycle_req),
    .expire  (ev_expire),
    .state   (state)
  );

  assign st_vec        = state_bits(state);
  assign st_reset      = st_vec[0];
  assign st_cycle      = st_vec[1];
  assign st_lockout    = st_vec[2];
  assign timing_active = tmr_armed && !hold_rst;

endmodule

// File: rtl/rrt_checker.sv
module rrt_checker (
  input logic clk,
  input logic rst,
  input logic reset_req,
  input logic cycle_req,
  input logic lockout_req,
  input logic hold_rst,
  input logic st_reset,
  input logic st_cycle,
  input logic st_lockout,
  input logic timing_active,
  input logic armed,
  input logic expire
);

  // R1
  onehot_state_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({st_reset, st_cycle, st_lockout}) == 1);

  // R4
  hold_keeps_armed_chk: assert property (@(posedge clk) disable iff (rst)
    armed && hold_rst && !cycle_req && !lockout_req |=> armed && !st_reset);

  // R6
  active_flag_chk: assert property (@(posedge clk) disable iff (rst)
    timing_active |-> !hold_rst && !st_reset);

  // R8
  lockout_wins_chk: assert property (@(posedge clk) disable iff (rst)
    lockout_req |=> st_lockout && !armed);

  // R8
  cycle_enter_chk: assert property (@(posedge clk) disable iff (rst)
    cycle_req && !lockout_req |=> st_cycle && !armed);

  // R2
  expire_to_reset_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> st_reset && !timing_active);

  // R9
  reset_state_idle_chk: assert property (@(posedge clk) disable iff (rst)
    st_reset |-> !armed);

  // R10
  sync_reset_chk: assert property (@(posedge clk)
    rst |=> st_reset && !armed);

endmodule

bind reclose_reset_timer rrt_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .reset_req     (reset_req),
  .cycle_req     (cycle_req),
  .lockout_req   (lockout_req),
  .hold_rst      (hold_rst),
  .st_reset      (st_reset),
  .st_cycle      (st_cycle),
  .st_lockout    (st_lockout),
  .timing_active (timing_active),
  .armed         (tmr_armed),
  .expire        (ev_expire)
);

// File: tb/reclose_reset_timer_bench.sv
module reclose_reset_timer_bench;

  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reset_req = 1'b0;
  logic          cycle_req = 1'b0;
  logic          lockout_req = 1'b0;
  logic          hold_rst = 1'b0;
  logic [TW-1:0] cyc_time = '0;
  logic [TW-1:0] lko_time = '0;
  logic          st_reset, st_cycle, st_lockout, timing_active;

  int checks = 0;
  int fails = 0;
  int ticks = 0;

  // reference model: 0 = Reset, 1 = Cycle, 2 = Lockout
  int m_state = 0;
  bit m_run = 0;
  int m_left = 0;

  always #2 clk = ~clk;

  reclose_reset_timer #(.TW(TW)) u_reclose_reset_timer (
    .clk(clk), .rst(rst), .reset_req(reset_req), .cycle_req(cycle_req),
    .lockout_req(lockout_req), .hold_rst(hold_rst), .cyc_time(cyc_time),
    .lko_time(lko_time), .st_reset(st_reset), .st_cycle(st_cycle),
    .st_lockout(st_lockout), .timing_active(timing_active)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int interval_for(input int s);
    return (s == 2) ? int'(lko_time) : int'(cyc_time);
  endfunction

  function automatic int seen_state();
    return st_lockout ? 2 : (st_cycle ? 1 : (st_reset ? 0 : 9));
  endfunction

  task automatic compare_model();
    int ones = int'(st_reset) + int'(st_cycle) + int'(st_lockout);
    check(ones == 1 && seen_state() == m_state, "R1 state", seen_state(), m_state);
    check(timing_active == (m_run && !hold_rst), "R6 active", timing_active,
          int'(m_run && !hold_rst));
  endtask

  task automatic model_edge();
    if (rst) begin
      m_state = 0; m_run = 0; m_left = 0;
    end else if (lockout_req) begin
      m_state = 2; m_run = 0;
    end else if (cycle_req) begin
      m_state = 1; m_run = 0;
    end else if (m_run) begin
      if (hold_rst) m_left = interval_for(m_state);
      else if (m_left == 0) begin m_run = 0; m_state = 0; end
      else m_left = m_left - 1;
    end else if (reset_req && m_state != 0) begin
      m_run = 1; m_left = interval_for(m_state);
    end
  endtask

  task automatic step(input bit r, input bit rq, input bit cy, input bit lk, input bit bk);
    @(negedge clk);
    rst = r; reset_req = rq; cycle_req = cy; lockout_req = lk; hold_rst = bk;
    #1;
    compare_model();
    @(posedge clk);
    model_edge();
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  // counts edges (idle, hold low) until Reset is seen
  task automatic edges_to_reset(input int exp, input string req);
    int n = 0;
    bit seen = 0;
    while (!seen && n < 80) begin
      step(0, 0, 0, 0, 0);
      n++;
      if (st_reset) seen = 1;
    end
    check(seen && n == exp, req, n, exp);
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", ticks);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    check(st_reset && !st_cycle && !st_lockout && !timing_active, "R10 reset state",
          seen_state(), 0);

    // R9: reset_req ignored in Reset state
    cyc_time = 16'd5; lko_time = 16'd3;
    step(0, 1, 0, 0, 0);
    check(st_reset && !timing_active, "R9 req in Reset", timing_active, 0);

    // R2: cycle interval 5 -> 6 edges
    step(0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0);
    check(timing_active, "R6 active after arm", timing_active, 1);
    edges_to_reset(6, "R2 cycle interval");

    // R3: lockout interval 3 -> 4 edges
    step(0, 0, 0, 1, 0);
    check(st_lockout, "R8 lockout entry", seen_state(), 2);
    step(0, 1, 0, 0, 0);
    edges_to_reset(4, "R3 lockout interval");

    // R7: zero interval
    cyc_time = 16'd0;
    step(0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0);
    edges_to_reset(1, "R7 zero interval");

    // R4/R5: hold midway, full restart after release
    cyc_time = 16'd4;
    step(0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0);
    idle(2);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1);
    check(st_cycle && !timing_active, "R4 hold freezes", seen_state(), 1);
    edges_to_reset(5, "R5 full reload");

    // R9: re-request while running does not restart
    cyc_time = 16'd6;
    step(0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0);
    idle(3);
    step(0, 1, 0, 0, 0);
    edges_to_reset(3, "R9 no restart");

    // R8: lockout during timing aborts; lockout wins over cycle
    step(0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0);
    idle(2);
    step(0, 0, 1, 1, 0);
    check(st_lockout && !timing_active, "R8 abort to lockout", seen_state(), 2);

    // R11: request at expiry edge wins
    cyc_time = 16'd2;
    step(0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0);
    idle(2);
    step(0, 0, 0, 1, 0);
    check(st_lockout, "R11 request beats expiry", seen_state(), 2);

    // R11: hold at expiry edge blocks it and reloads
    step(0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0);
    idle(2);
    step(0, 0, 0, 0, 1);
    check(st_cycle, "R11 hold beats expiry", seen_state(), 1);
    edges_to_reset(3, "R11 reload after hold");

    // mixed stimulus against the model (R1 R6)
    for (int i = 0; i < 3000; i++) begin
      int p = int'($urandom_range(0, 99));
      if (i % 400 == 0) begin
        cyc_time = 16'($urandom_range(0, 7));
        lko_time = 16'($urandom_range(0, 7));
      end
      step(p == 0, p < 25, p >= 95 && p < 98, p >= 98, $urandom_range(0, 9) < 2);
    end

    // R10: reset from mid-timing
    step(0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    check(st_reset && !timing_active, "R10 reset mid-timing", seen_state(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule